// File: doc/BRIEF.md
# Indirect DMA Channel Programming Port

This block is the host-facing programming port of a multi-channel DMA controller. Software sees only two byte-wide I/O locations. A write to the command location carries a command byte. Its upper nibble picks an operation and its lower nibble picks a channel. The data location then moves the bytes that belong to that operation, one access at a time, least significant byte first. The port holds each channel's register set, steps an internal byte pointer, and drives every channel's register values in parallel to the transfer engines.

A sequencer state machine tracks the operation that is open. Its states are `ST_IDLE` (no open operation), `ST_SET_IO`, `ST_SET_ADDR`, `ST_GET_ADDR`, `ST_SET_CNT`, `ST_GET_CNT`, `ST_GET_STAT`, `ST_SET_MODE` and `ST_SET_ARB`. There are four transitions:

- **open**: a command write moves from any state to the decoded state, or to `ST_IDLE` for immediate, unknown or out-of-range commands. It clears the pointer.
- **step**: an accepted data byte that is not the last one advances the pointer and keeps the state.
- **finish**: an accepted data byte that is the last one returns to `ST_IDLE`.
- **hold**: any other access leaves the state and the pointer as they are.

Mask, unmask and master clear act in the same cycle as their command write and need no data bytes.

Top module: `dmafe_top`

## Requirements
- R1: After reset every channel is masked, all address, count, port, arbitration and mode values are zero, all status flags are clear, and a data read returns 0x00.
- R2: Command bytes are taken only at I/O offset 0x18 and data bytes only at offset 0x1A. Bits [7:4] of a command byte are the operation and bits [3:0] the channel. Accesses at other offsets have no effect.
- R3: Operation 0x2 (set address) takes three data writes, low byte first, into the channel's 24-bit address.
- R4: Operation 0x3 (get address) returns the channel's address over three data reads, low byte first.
- R5: Operation 0x4 (set count) takes two data writes, low byte first, into the 16-bit count. Operation 0x5 (get count) returns the count over two reads, low byte first.
- R6: Operation 0x0 (set I/O port) takes two data writes, low byte first, into the channel's 16-bit port number.
- R7: Operation 0x7 (set mode) takes one byte. Bit 2 enables transfers. Bit 3 selects device-to-memory instead of memory-to-device. Bit 0 selects an I/O-port target. Bit 6 selects 16-bit transfers.
- R8: Operation 0x8 (set arbitration level) takes one byte and keeps its low 4 bits.
- R9: Operation 0x9 masks and operation 0xA unmasks the addressed channel on the command write itself, with no data bytes.
- R10: Any command write sets the byte pointer back to zero. An interrupted sequence therefore restarts at its low byte, and a stray data byte after an immediate command changes nothing.
- R11: Data accesses past an operation's byte count, or in the wrong direction for it, are ignored. Reads that are not served return 0x00.
- R12: Operation 0x6 (get status) returns one byte in which bit k is set once a pulse has arrived on `tc_in[k]`. Reading that byte clears the flags, but a pulse in the same cycle as the read stays set.
- R13: Operation 0xD (master clear), whatever its channel nibble, masks every channel, clears every mode register and closes the open sequence. It leaves the address, count, port and arbitration values as they are.
- R14: A command whose channel nibble is 8 or more (the channel count or more) is ignored and closes the open sequence. Get status and master clear are exempt, since they ignore the nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O offset of the access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, valid while io_rd is high |
| tc_in | input | 8 | Terminal-count pulse per channel |
| ch_addr | output | 192 | Channel addresses, 24 bits each, channel 0 lowest |
| ch_count | output | 128 | Channel counts, 16 bits each |
| ch_ioport | output | 128 | Channel I/O port numbers, 16 bits each |
| ch_arb | output | 32 | Channel arbitration levels, 4 bits each |
| ch_xfer_en | output | 8 | Transfer enable per channel |
| ch_to_mem | output | 8 | Device-to-memory direction per channel |
| ch_io_tgt | output | 8 | I/O-port target per channel |
| ch_wide | output | 8 | 16-bit transfers per channel |
| ch_mask | output | 8 | Channel masked |

## Verification
The in-line properties watch several rules on every cycle:
- A command write leaves the pointer at zero.
- The pointer stays inside the open operation's byte count, and the last byte closes the sequence.
- Mask and master clear take effect in the cycle after their command.
- A status read with no incoming pulse empties the flags.
- Reads while idle return zero.

Only the bench scenarios can show the byte ordering of each multi-byte register. They also show that a restarted sequence overwrites only the low byte, and that out-of-range channels and wrong-direction accesses leave every register untouched. The survival of a pulse that coincides with the clearing read is likewise shown only by a scenario.

// File: rtl/dmafe_pkg.sv
package dmafe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SET_IO,
        ST_SET_ADDR,
        ST_GET_ADDR,
        ST_SET_CNT,
        ST_GET_CNT,
        ST_GET_STAT,
        ST_SET_MODE,
        ST_SET_ARB
    } seq_state_e;

    localparam logic [3:0] OP_SET_IO   = 4'h0;
    localparam logic [3:0] OP_SET_ADDR = 4'h2;
    localparam logic [3:0] OP_GET_ADDR = 4'h3;
    localparam logic [3:0] OP_SET_CNT  = 4'h4;
    localparam logic [3:0] OP_GET_CNT  = 4'h5;
    localparam logic [3:0] OP_GET_STAT = 4'h6;
    localparam logic [3:0] OP_SET_MODE = 4'h7;
    localparam logic [3:0] OP_SET_ARB  = 4'h8;
    localparam logic [3:0] OP_MASK     = 4'h9;
    localparam logic [3:0] OP_UNMASK   = 4'hA;
    localparam logic [3:0] OP_CLEAR    = 4'hD;

endpackage

// File: rtl/dmafe_decode.sv
module dmafe_decode
    import dmafe_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [7:0]  cmd,
    output seq_state_e  nxt_state,
    output logic        do_mask,
    output logic        do_unmask,
    output logic        do_clear
);
    localparam logic [4:0] NCH_L = 5'(NCH);

    logic ch_ok;

    always_comb begin
        ch_ok     = {1'b0, cmd[3:0]} < NCH_L;
        nxt_state = ST_IDLE;
        do_mask   = 1'b0;
        do_unmask = 1'b0;
        do_clear  = 1'b0;
        unique case (cmd[7:4])
            OP_SET_IO:   if (ch_ok) nxt_state = ST_SET_IO;
            OP_SET_ADDR: if (ch_ok) nxt_state = ST_SET_ADDR;
            OP_GET_ADDR: if (ch_ok) nxt_state = ST_GET_ADDR;
            OP_SET_CNT:  if (ch_ok) nxt_state = ST_SET_CNT;
            OP_GET_CNT:  if (ch_ok) nxt_state = ST_GET_CNT;
            OP_GET_STAT: nxt_state = ST_GET_STAT;
            OP_SET_MODE: if (ch_ok) nxt_state = ST_SET_MODE;
            OP_SET_ARB:  if (ch_ok) nxt_state = ST_SET_ARB;
            OP_MASK:     do_mask   = ch_ok;
            OP_UNMASK:   do_unmask = ch_ok;
            OP_CLEAR:    do_clear  = 1'b1;
            default:     nxt_state = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/dmafe_seq.sv
module dmafe_seq
    import dmafe_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int CNT_BYTES  = 2,
    parameter int PORT_BYTES = 2,
    parameter int PTRW       = 2,
    parameter int CHW        = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_wr,
    input  logic            data_wr,
    input  logic            data_rd,
    input  seq_state_e      nxt_state,
    input  logic [CHW-1:0]  cmd_ch,
    output seq_state_e      state_o,
    output logic [CHW-1:0]  ch_o,
    output logic [PTRW-1:0] ptr_o,
    output logic            wr_step,
    output logic            rd_step
);
    seq_state_e      state_q;
    logic [CHW-1:0]  ch_q;
    logic [PTRW-1:0] ptr_q;
    logic            last_byte;

    function automatic int len_of(seq_state_e s);
        case (s)
            ST_SET_IO:                  return PORT_BYTES;
            ST_SET_ADDR, ST_GET_ADDR:   return ADDR_BYTES;
            ST_SET_CNT, ST_GET_CNT:     return CNT_BYTES;
            ST_GET_STAT, ST_SET_MODE,
            ST_SET_ARB:                 return 1;
            default:                    return 0;
        endcase
    endfunction

    // state register: open, step, finish, hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
            ptr_q   <= '0;
        end else if (cmd_wr) begin
            state_q <= nxt_state;
            ch_q    <= cmd_ch;
            ptr_q   <= '0;
        end else if (wr_step || rd_step) begin
            if (last_byte) begin
                state_q <= ST_IDLE;
                ptr_q   <= '0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wr_step = 1'b0;
        rd_step = 1'b0;
        unique case (state_q)
            ST_SET_IO, ST_SET_ADDR, ST_SET_CNT,
            ST_SET_MODE, ST_SET_ARB:             wr_step = data_wr;
            ST_GET_ADDR, ST_GET_CNT, ST_GET_STAT: rd_step = data_rd;
            default: ;
        endcase
        last_byte = int'(ptr_q) == len_of(state_q) - 1;
        state_o   = state_q;
        ch_o      = ch_q;
        ptr_o     = ptr_q;
    end

    a_r10_cmd_zeroes_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> ptr_q == '0);
    a_r11_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (int'(ptr_q) < len_of(state_q)));
    a_r11_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && (wr_step || rd_step) && last_byte) |=> state_q == ST_IDLE);
endmodule

// File: rtl/dmafe_chregs.sv
module dmafe_chregs
    import dmafe_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int AW   = 24,
    parameter int CW   = 16,
    parameter int PW   = 16,
    parameter int ARBW = 4,
    parameter int PTRW = 2,
    parameter int CHW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic [CHW-1:0]    ch,
    input  logic [PTRW-1:0]   ptr,
    input  logic              wr_step,
    input  logic              rd_step,
    input  logic [7:0]        wdata,
    input  logic              do_mask,
    input  logic              do_unmask,
    input  logic              do_clear,
    input  logic [CHW-1:0]    mask_ch,
    input  logic [NCH-1:0]    tc_in,
    output logic [7:0]        rd_byte,
    output logic [NCH*AW-1:0] ch_addr,
    output logic [NCH*CW-1:0] ch_count,
    output logic [NCH*PW-1:0] ch_ioport,
    output logic [NCH*ARBW-1:0] ch_arb,
    output logic [NCH-1:0]    ch_xfer_en,
    output logic [NCH-1:0]    ch_to_mem,
    output logic [NCH-1:0]    ch_io_tgt,
    output logic [NCH-1:0]    ch_wide,
    output logic [NCH-1:0]    ch_mask
);
    localparam int SB = (NCH < 8) ? NCH : 8;

    logic [AW-1:0]  addr_arr  [NCH];
    logic [CW-1:0]  count_arr [NCH];
    logic [NCH-1:0] flag_q;
    logic [7:0]     stat_byte;
    logic           stat_clr;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic [AW-1:0]   addr_q;
        logic [CW-1:0]   count_q;
        logic [PW-1:0]   port_q;
        logic [ARBW-1:0] arb_q;
        logic [3:0]      mode_q;
        logic            mask_q;
        logic            sel;

        assign sel = (ch == CHW'(k));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q  <= '0;
                count_q <= '0;
                port_q  <= '0;
                arb_q   <= '0;
                mode_q  <= '0;
                mask_q  <= 1'b1;
            end else if (do_clear) begin
                mode_q <= '0;
                mask_q <= 1'b1;
            end else begin
                if (do_mask && mask_ch == CHW'(k))   mask_q <= 1'b1;
                if (do_unmask && mask_ch == CHW'(k)) mask_q <= 1'b0;
                if (wr_step && sel) begin
                    unique case (state)
                        ST_SET_ADDR: addr_q[8*int'(ptr) +: 8]  <= wdata;
                        ST_SET_CNT:  count_q[8*int'(ptr) +: 8] <= wdata;
                        ST_SET_IO:   port_q[8*int'(ptr) +: 8]  <= wdata;
                        ST_SET_MODE: mode_q <= {wdata[6], wdata[3], wdata[2], wdata[0]};
                        ST_SET_ARB:  arb_q  <= wdata[ARBW-1:0];
                        default: ;
                    endcase
                end
            end
        end

        assign addr_arr[k]              = addr_q;
        assign count_arr[k]             = count_q;
        assign ch_addr[k*AW +: AW]      = addr_q;
        assign ch_count[k*CW +: CW]     = count_q;
        assign ch_ioport[k*PW +: PW]    = port_q;
        assign ch_arb[k*ARBW +: ARBW]   = arb_q;
        assign ch_wide[k]               = mode_q[3];
        assign ch_to_mem[k]             = mode_q[2];
        assign ch_xfer_en[k]            = mode_q[1];
        assign ch_io_tgt[k]             = mode_q[0];
        assign ch_mask[k]               = mask_q;
    end

    assign stat_clr = rd_step && (state == ST_GET_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (stat_clr && i < 8) flag_q[i] <= tc_in[i];
                else                   flag_q[i] <= flag_q[i] | tc_in[i];
            end
        end
    end

    always_comb begin
        stat_byte = '0;
        for (int i = 0; i < SB; i++) stat_byte[i] = flag_q[i];
        rd_byte = '0;
        unique case (state)
            ST_GET_ADDR: rd_byte = addr_arr[ch][8*int'(ptr) +: 8];
            ST_GET_CNT:  rd_byte = count_arr[ch][8*int'(ptr) +: 8];
            ST_GET_STAT: rd_byte = stat_byte;
            default:     rd_byte = '0;
        endcase
    end

    a_r12_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && tc_in == '0) |=> stat_byte == 8'h00);
endmodule

// File: rtl/dmafe_top.sv
module dmafe_top
    import dmafe_pkg::*;
#(
    parameter int         NCH      = 8,
    parameter int         AW       = 24,
    parameter int         CW       = 16,
    parameter int         PW       = 16,
    parameter int         ARBW     = 4,
    parameter logic [7:0] CMD_OFS  = 8'h18,
    parameter logic [7:0] DATA_OFS = 8'h1A
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    input  logic [NCH-1:0]       tc_in,
    output logic [NCH*AW-1:0]    ch_addr,
    output logic [NCH*CW-1:0]    ch_count,
    output logic [NCH*PW-1:0]    ch_ioport,
    output logic [NCH*ARBW-1:0]  ch_arb,
    output logic [NCH-1:0]       ch_xfer_en,
    output logic [NCH-1:0]       ch_to_mem,
    output logic [NCH-1:0]       ch_io_tgt,
    output logic [NCH-1:0]       ch_wide,
    output logic [NCH-1:0]       ch_mask
);
    localparam int ADDR_BYTES = AW / 8;
    localparam int CNT_BYTES  = CW / 8;
    localparam int PORT_BYTES = PW / 8;
    localparam int MAXB_AC    = (ADDR_BYTES > CNT_BYTES) ? ADDR_BYTES : CNT_BYTES;
    localparam int MAXB       = (MAXB_AC > PORT_BYTES) ? MAXB_AC : PORT_BYTES;
    localparam int PTRW       = (MAXB > 1) ? $clog2(MAXB) : 1;
    localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [4:0] NCH_L = 5'(NCH);

    logic            cmd_wr, data_wr, data_rd;
    logic            do_mask, do_unmask, do_clear;
    logic            wr_step, rd_step;
    seq_state_e      nxt_state, state;
    logic [CHW-1:0]  ch;
    logic [PTRW-1:0] ptr;
    logic [7:0]      rd_byte;

    assign cmd_wr  = io_wr && (io_addr == CMD_OFS);
    assign data_wr = io_wr && (io_addr == DATA_OFS);
    assign data_rd = io_rd && (io_addr == DATA_OFS);

    dmafe_decode #(.NCH(NCH)) u_dec (
        .cmd(io_wdata), .nxt_state(nxt_state),
        .do_mask(do_mask), .do_unmask(do_unmask), .do_clear(do_clear)
    );

    dmafe_seq #(
        .ADDR_BYTES(ADDR_BYTES), .CNT_BYTES(CNT_BYTES), .PORT_BYTES(PORT_BYTES),
        .PTRW(PTRW), .CHW(CHW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
        .data_rd(data_rd), .nxt_state(nxt_state), .cmd_ch(io_wdata[CHW-1:0]),
        .state_o(state), .ch_o(ch), .ptr_o(ptr),
        .wr_step(wr_step), .rd_step(rd_step)
    );

    dmafe_chregs #(
        .NCH(NCH), .AW(AW), .CW(CW), .PW(PW), .ARBW(ARBW), .PTRW(PTRW), .CHW(CHW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .state(state), .ch(ch), .ptr(ptr),
        .wr_step(wr_step), .rd_step(rd_step), .wdata(io_wdata),
        .do_mask(do_mask && cmd_wr), .do_unmask(do_unmask && cmd_wr),
        .do_clear(do_clear && cmd_wr), .mask_ch(io_wdata[CHW-1:0]),
        .tc_in(tc_in), .rd_byte(rd_byte),
        .ch_addr(ch_addr), .ch_count(ch_count), .ch_ioport(ch_ioport),
        .ch_arb(ch_arb), .ch_xfer_en(ch_xfer_en), .ch_to_mem(ch_to_mem),
        .ch_io_tgt(ch_io_tgt), .ch_wide(ch_wide), .ch_mask(ch_mask)
    );

    assign io_rdata = data_rd ? rd_byte : 8'h00;

    a_r9_mask_now: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && io_wdata[7:4] == OP_MASK && {1'b0, io_wdata[3:0]} < NCH_L)
        |=> ch_mask[$past(io_wdata[CHW-1:0])]);
    a_r13_clear_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && io_wdata[7:4] == OP_CLEAR) |=> (&ch_mask));
    a_r13_clear_modes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && io_wdata[7:4] == OP_CLEAR) |=> (ch_xfer_en == '0 && ch_wide == '0));
    a_r11_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && io_rd) |-> io_rdata == 8'h00);
endmodule

// File: tb/dmafe_top_test.sv
module dmafe_top_test;
    localparam logic [7:0] CMD  = 8'h18;
    localparam logic [7:0] DAT  = 8'h1A;
    localparam int NV = 24;
    // {kind, byte, expected}: kind 0 command write, 1 data write, 2 data read
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 8'h23, 8'h00}, {2'd1, 8'h11, 8'h00}, {2'd1, 8'h22, 8'h00},
        {2'd1, 8'h33, 8'h00}, {2'd0, 8'h33, 8'h00}, {2'd2, 8'h00, 8'h11},
        {2'd2, 8'h00, 8'h22}, {2'd2, 8'h00, 8'h33}, {2'd2, 8'h00, 8'h00},
        {2'd0, 8'h45, 8'h00}, {2'd1, 8'hCD, 8'h00}, {2'd1, 8'hAB, 8'h00},
        {2'd0, 8'h55, 8'h00}, {2'd2, 8'h00, 8'hCD}, {2'd2, 8'h00, 8'hAB},
        {2'd2, 8'h00, 8'h00}, {2'd0, 8'h35, 8'h00}, {2'd2, 8'h00, 8'h00},
        {2'd0, 8'h23, 8'h00}, {2'd1, 8'h44, 8'h00}, {2'd0, 8'h33, 8'h00},
        {2'd2, 8'h00, 8'h44}, {2'd2, 8'h00, 8'h22}, {2'd2, 8'h00, 8'h33}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   io_addr = '0, io_wdata = '0;
    logic         io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]   io_rdata, tc_in = '0;
    logic [191:0] ch_addr;
    logic [127:0] ch_count, ch_ioport;
    logic [31:0]  ch_arb;
    logic [7:0]   ch_xfer_en, ch_to_mem, ch_io_tgt, ch_wide, ch_mask;
    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] got;

    always #4 clk = ~clk;

    dmafe_top uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .tc_in(tc_in),
        .ch_addr(ch_addr), .ch_count(ch_count), .ch_ioport(ch_ioport),
        .ch_arb(ch_arb), .ch_xfer_en(ch_xfer_en), .ch_to_mem(ch_to_mem),
        .ch_io_tgt(ch_io_tgt), .ch_wide(ch_wide), .ch_mask(ch_mask)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [7:0] a, input bit w, input bit r,
                          input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
        #1 q = io_rdata;
        @(posedge clk);
        #1 io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);
        logic [7:0] q;
        access(CMD, 1'b1, 1'b0, b, q);
    endtask

    task automatic dwr(input logic [7:0] b);
        logic [7:0] q;
        access(DAT, 1'b1, 1'b0, b, q);
    endtask

    task automatic drd(output logic [7:0] q);
        access(DAT, 1'b0, 1'b1, 8'h00, q);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        chk("R1 mask", 32'(ch_mask), 32'hFF);
        chk("R1 addr", 32'(ch_addr[3*24 +: 24]), 32'h0);
        chk("R1 xfer", 32'(ch_xfer_en), 32'h0);
        drd(got);
        chk("R1 idle read", 32'(got), 32'h0);

        // table walk: R3 R4 R5 R10 R11 read-backs
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][17:16] == 2'd0 ? CMD : DAT, VEC[i][17:16] != 2'd2,
                   VEC[i][17:16] == 2'd2, VEC[i][15:8], got);
            if (VEC[i][17:16] == 2'd2) chk("R4 R5 R10 R11 table read", 32'(got), 32'(VEC[i][7:0]));
        end
        chk("R3 R10 address after restart", 32'(ch_addr[3*24 +: 24]), 32'h332244);
        chk("R5 count", 32'(ch_count[5*16 +: 16]), 32'hABCD);

        // R6 port
        cmd(8'h02); dwr(8'h34); dwr(8'h12);
        chk("R6 port", 32'(ch_ioport[2*16 +: 16]), 32'h1234);

        // R7 mode decode
        cmd(8'h71); dwr(8'h4D);
        chk("R7 all bits", {28'h0, ch_wide[1], ch_to_mem[1], ch_xfer_en[1], ch_io_tgt[1]}, 32'hF);
        cmd(8'h76); dwr(8'h04);
        chk("R7 read only", {28'h0, ch_wide[6], ch_to_mem[6], ch_xfer_en[6], ch_io_tgt[6]}, 32'h2);

        // R8 arbitration
        cmd(8'h84); dwr(8'h3A);
        chk("R8 arb", 32'(ch_arb[4*4 +: 4]), 32'hA);

        // R9 unmask/mask
        cmd(8'hA3);
        chk("R9 unmask", 32'(ch_mask), 32'hF7);
        cmd(8'hA1);
        chk("R9 unmask two", 32'(ch_mask), 32'hF5);
        cmd(8'h21); dwr(8'h55); cmd(8'h91); dwr(8'h66);
        chk("R9 mask", 32'(ch_mask), 32'hF7);
        chk("R10 stray byte", 32'(ch_addr[1*24 +: 24]), 32'h000055);

        // R11 wrong direction, R2 other offset
        cmd(8'h53); dwr(8'h77); drd(got);
        chk("R11 wrong dir read", 32'(got), 32'h0);
        chk("R11 count kept", 32'(ch_count[3*16 +: 16]), 32'h0);
        access(8'h19, 1'b1, 1'b0, 8'h24, got);
        dwr(8'h11);
        chk("R2 other offset", 32'(ch_addr[4*24 +: 24]), 32'h0);

        // R14 channel out of range
        cmd(8'h2B); dwr(8'h77); dwr(8'h77); dwr(8'h77);
        chk("R14 addr ch3 kept", 32'(ch_addr[3*24 +: 24]), 32'h332244);
        cmd(8'hA8);
        chk("R14 unmask ignored", 32'(ch_mask), 32'hF7);

        // R12 status flags
        @(negedge clk) tc_in = 8'h05;
        @(negedge clk) tc_in = 8'h00;
        cmd(8'h60); drd(got);
        chk("R12 flags", 32'(got), 32'h05);
        cmd(8'h60); drd(got);
        chk("R12 cleared", 32'(got), 32'h00);
        cmd(8'h60);
        @(negedge clk);
        io_addr = DAT; io_rd = 1'b1; tc_in = 8'h80;
        #1 got = io_rdata;
        @(posedge clk);
        #1 io_rd = 1'b0; tc_in = 8'h00;
        chk("R12 read before pulse", 32'(got), 32'h00);
        cmd(8'h60); drd(got);
        chk("R12 coincident pulse kept", 32'(got), 32'h80);

        // R13 master clear
        cmd(8'h23); dwr(8'h01); cmd(8'hD5); dwr(8'h02);
        chk("R13 masks", 32'(ch_mask), 32'hFF);
        chk("R13 modes", 32'({ch_xfer_en, ch_wide, ch_io_tgt, ch_to_mem}), 32'h0);
        chk("R13 addr kept", 32'(ch_addr[3*24 +: 24]), 32'h332201);
        chk("R13 arb kept", 32'(ch_arb[4*4 +: 4]), 32'hA);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule